// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block is a register-mapped bank of event counters for a performance monitor. It has four physical 32-bit counters, and each one can run either as one 32-bit count or as two independent 16-bit counts. When a physical counter is split, it carries two logical counters. This gives eight logical indices in all. Logical index `n` and index `n+4` both select physical counter `n`. In split mode, index `n` is the upper half and index `n+4` is the lower half.

Software never writes a running counter directly. A write goes into a holding register for that physical counter and marks it pending. Pending values move into the live counters only when the control register is written with its run bit set. This happens both when the monitor is first started and when the run bit is rewritten while the monitor is already running.

When a counter wraps, it sets a status flag. A read of the status register returns the flags and clears them in the same access. A write to the status address loads the interrupt enable mask instead. The interrupt output is high while any flag is set whose mask bit is also set.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter reads 0 and the control register reads 0 (stopped, all counters in 32-bit mode). The status register, the mask and `irq_out` are 0.
- R2: The register data field is bus bits [63:32], and bits [31:0] are ignored on write and read as 0.
  - Word addresses 0–7 are the logical counters, 8 is control and 9 is status.
  - Other addresses read 0 and ignore writes.
  - Read data appears with `rsp_valid` one cycle after the read request.
- R3: A counter write only loads the holding register of its physical counter and marks it pending. The live count is unchanged, and a readback returns the held value while the write is pending.
- R4: A control write with the run bit (field bit 0) set loads every pending holding value into its live counter and clears all pending marks. This also happens when the monitor is already running. A control write with the run bit clear commits nothing.
- R5: While running, a 32-bit-mode counter `n` adds 1 in each cycle that `evt_inc[n]` is high, and `evt_inc[n+4]` has no effect on it. While stopped, no counter changes except through a commit.
- R6: Field bit `1+n` of control puts physical counter `n` in split mode. `evt_inc[n]` then counts the upper half and `evt_inc[n+4]` counts the lower half. Each half wraps inside its own 16 bits and never carries into the other half.
- R7: In split mode, a read of index `n<4` returns the upper half and a read of index `n+4` returns the lower half, each zero-extended. A write to one half keeps the other half at its current readback value.
- R8: A counting wrap from all ones to zero sets status bit `i`, where `i` is the logical index of the count. A 32-bit counter `n` uses bit `n`.
- R9: A status read returns the flags in field bits [7:0] and clears them. A wrap in the same cycle as that read stays set.
- R10: A status write loads the interrupt mask from field bits [7:0]. `irq_out` is high exactly when some flag and its mask bit are both set, so a mask of 0 keeps `irq_out` low.
- R11: If a commit and an increment fall in the same cycle, the committed value is stored, no increment is counted and no wrap is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 64 | Write data, register field in [63:32] |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data, register field in [63:32] |
| evt_inc | input | 8 | Per-logical-counter increment request |
| irq_out | output | 1 | Masked overflow interrupt |

## Verification
The assertions check the following on every cycle:
- a stopped counter holds its value;
- a split lower half that wraps leaves its upper half alone;
- a commit clears all pending marks and loads the held value;
- status flags rise only on a wrap and clear on a read;
- a response follows each read.

Some behaviours need whole scenarios from the bench's cycle-level model:
- the exact readback values;
- the preservation of the other half on a half-write;
- the re-commit while already running;
- the priority between an increment and a commit;
- a wrap that lands in the same cycle as a clearing status read.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int PCB_PHYS_DEF  = 4;
    localparam int PCB_CNT_W_DEF = 32;
    localparam int PCB_BUS_W_DEF = 64;

    // Control field layout: run bit, then one split-mode bit per physical counter.
    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_SPLIT_LSB = 1;

    typedef enum logic [1:0] {
        RK_COUNTER,
        RK_CONTROL,
        RK_STATUS,
        RK_HOLE
    } reg_kind_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        reg_kind_e kind;
    } bus_op_t;

    // Counters occupy the first n_log words, then control, then status.
    function automatic reg_kind_e classify(int unsigned addr, int unsigned n_log);
        if (addr < n_log)           return RK_COUNTER;
        else if (addr == n_log)     return RK_CONTROL;
        else if (addr == n_log + 1) return RK_STATUS;
        else                        return RK_HOLE;
    endfunction

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
    import pcb_pkg::*;
#(
    parameter int NUM_PHYS = PCB_PHYS_DEF,
    parameter int REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [REG_W-1:0]    wval,
    output logic                run,
    output logic [NUM_PHYS-1:0] split,
    output logic                commit,
    output logic [REG_W-1:0]    rd_word
);
    logic unused_hi;
    assign unused_hi = ^wval[REG_W-1:CTRL_SPLIT_LSB+NUM_PHYS];

    // Every control write with the run bit set pushes pending values live.
    assign commit = wr & wval[CTRL_RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            split <= '0;
        end else if (wr) begin
            run   <= wval[CTRL_RUN_BIT];
            split <= wval[CTRL_SPLIT_LSB +: NUM_PHYS];
        end
    end

    assign rd_word = REG_W'({split, run});

    a_r4_run_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> run == $past(wval[CTRL_RUN_BIT]));

endmodule

// File: rtl/pcb_slice.sv
module pcb_slice #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             split,
    input  logic             commit,
    input  logic             wr_en,
    input  logic             wr_lo,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             inc_hi,
    input  logic             inc_lo,
    output logic [CNT_W-1:0] view,
    output logic             pending,
    output logic             ovf_hi,
    output logic             ovf_lo
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  live, hold, live_nx, hold_nx;
    logic [HALF_W-1:0] live_hi, live_lo, view_hi, view_lo;
    logic              load, hi_full, lo_full, all_full;

    assign live_hi  = live[CNT_W-1:HALF_W];
    assign live_lo  = live[HALF_W-1:0];
    assign view     = pending ? hold : live;
    assign view_hi  = view[CNT_W-1:HALF_W];
    assign view_lo  = view[HALF_W-1:0];
    assign load     = commit & pending;
    assign hi_full  = &live_hi;
    assign lo_full  = &live_lo;
    assign all_full = &live;

    assign ovf_hi = run & ~load & inc_hi & (split ? hi_full : all_full);
    assign ovf_lo = run & ~load & split & inc_lo & lo_full;

    always_comb begin
        if (load)
            live_nx = hold;
        else if (run && split)
            live_nx = {live_hi + HALF_W'(inc_hi), live_lo + HALF_W'(inc_lo)};
        else if (run)
            live_nx = live + CNT_W'(inc_hi);
        else
            live_nx = live;
    end

    always_comb begin
        if (!split)
            hold_nx = wr_val;
        else if (wr_lo)
            hold_nx = {view_hi, wr_val[HALF_W-1:0]};
        else
            hold_nx = {wr_val[HALF_W-1:0], view_lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live    <= '0;
            hold    <= '0;
            pending <= 1'b0;
        end else begin
            live <= live_nx;
            if (wr_en) begin
                hold    <= hold_nx;
                pending <= 1'b1;
            end else if (commit) begin
                pending <= 1'b0;
            end
        end
    end

    a_r3_write_marks_pending: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pending);

    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(live));

    a_r6_halves_no_carry: assert property (@(posedge clk) disable iff (rst)
        (run && split && !load && inc_lo && lo_full && !inc_hi)
        |=> $stable(live[CNT_W-1:HALF_W]));

    a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> live == $past(hold));

endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
    parameter int NUM_LOG = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LOG-1:0] ovf,
    input  logic               clr,
    input  logic               mask_wr,
    input  logic [NUM_LOG-1:0] mask_val,
    output logic [NUM_LOG-1:0] status,
    output logic [NUM_LOG-1:0] mask,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            // A wrap landing on the clearing read survives it.
            status <= (clr ? '0 : status) | ovf;
            if (mask_wr)
                mask <= mask_val;
        end
    end

    assign irq = |(status & mask);

    a_r8_flags_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (ovf == '0) |=> (status & ~$past(status)) == '0);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && ovf == '0) |=> status == '0);

    a_r10_mask_load: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> mask == $past(mask_val));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
    import pcb_pkg::*;
#(
    parameter int  NUM_PHYS = PCB_PHYS_DEF,
    parameter int  CNT_W    = PCB_CNT_W_DEF,
    parameter int  BUS_W    = PCB_BUS_W_DEF,
    localparam int NUM_LOG  = 2 * NUM_PHYS,
    localparam int ADDR_W   = $clog2(NUM_LOG + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [BUS_W-1:0]   rsp_rdata,
    input  logic [NUM_LOG-1:0] evt_inc,
    output logic               irq_out
);
    localparam int REG_W  = BUS_W / 2;
    localparam int HALF_W = CNT_W / 2;
    localparam int LIDX_W = $clog2(NUM_LOG);
    localparam int PIDX_W = $clog2(NUM_PHYS);

    bus_op_t             op;
    logic [REG_W-1:0]    wval, rd_word, ctrl_word, ctr_word;
    logic [LIDX_W-1:0]   lidx;
    logic [PIDX_W-1:0]   pidx;
    logic                lo_sel, ctrl_wr, stat_rd, stat_wr, ctr_wr;
    logic                run, commit;
    logic [NUM_PHYS-1:0] split, pend;
    logic [NUM_LOG-1:0]  ovf, status, mask;
    logic [CNT_W-1:0]    view [NUM_PHYS];
    logic [CNT_W-1:0]    sel_view;
    logic                unused_lo;

    assign unused_lo = ^req_wdata[REG_W-1:0];

    assign op.rd   = req_valid & ~req_write;
    assign op.wr   = req_valid &  req_write;
    assign op.kind = classify(32'(req_addr), NUM_LOG);

    assign wval    = req_wdata[BUS_W-1:REG_W];
    assign lidx    = req_addr[LIDX_W-1:0];
    assign pidx    = lidx[PIDX_W-1:0];
    assign lo_sel  = lidx[LIDX_W-1];
    assign ctrl_wr = op.wr && op.kind == RK_CONTROL;
    assign stat_wr = op.wr && op.kind == RK_STATUS;
    assign stat_rd = op.rd && op.kind == RK_STATUS;
    assign ctr_wr  = op.wr && op.kind == RK_COUNTER;

    pcb_ctrl #(.NUM_PHYS(NUM_PHYS), .REG_W(REG_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wval    (wval),
        .run     (run),
        .split   (split),
        .commit  (commit),
        .rd_word (ctrl_word)
    );

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
        pcb_slice #(.CNT_W(CNT_W)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .run     (run),
            .split   (split[p]),
            .commit  (commit),
            .wr_en   (ctr_wr && pidx == PIDX_W'(p)),
            .wr_lo   (lo_sel),
            .wr_val  (wval[CNT_W-1:0]),
            .inc_hi  (evt_inc[p]),
            .inc_lo  (evt_inc[p+NUM_PHYS]),
            .view    (view[p]),
            .pending (pend[p]),
            .ovf_hi  (ovf[p]),
            .ovf_lo  (ovf[p+NUM_PHYS])
        );
    end

    pcb_status #(.NUM_LOG(NUM_LOG)) u_status (
        .clk      (clk),
        .rst      (rst),
        .ovf      (ovf),
        .clr      (stat_rd),
        .mask_wr  (stat_wr),
        .mask_val (wval[NUM_LOG-1:0]),
        .status   (status),
        .mask     (mask),
        .irq      (irq_out)
    );

    assign sel_view = view[pidx];

    always_comb begin
        if (!split[pidx])
            ctr_word = REG_W'(sel_view);
        else if (lo_sel)
            ctr_word = REG_W'(sel_view[HALF_W-1:0]);
        else
            ctr_word = REG_W'(sel_view[CNT_W-1:HALF_W]);
    end

    always_comb begin
        unique case (op.kind)
            RK_COUNTER: rd_word = ctr_word;
            RK_CONTROL: rd_word = ctrl_word;
            RK_STATUS:  rd_word = REG_W'(status);
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= op.rd;
            if (op.rd)
                rsp_rdata <= {rd_word, {REG_W{1'b0}}};
        end
    end

    a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        op.rd |=> rsp_valid);

    a_r2_no_rsp_without_read: assert property (@(posedge clk) disable iff (rst)
        !op.rd |=> !rsp_valid);

    a_r4_commit_clears_pending: assert property (@(posedge clk) disable iff (rst)
        commit |=> pend == '0);

    a_r10_no_irq_when_masked_off: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_out);

endmodule

// File: tb/tb_perf_ctr_bank.sv
`timescale 1ns/1ps
module tb_perf_ctr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr  = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [7:0]  evt_inc = '0;
    logic        irq_out;

    always #2 clk = ~clk;

    perf_ctr_bank dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .evt_inc   (evt_inc),
        .irq_out   (irq_out)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string cur_tag = "R2";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_live [4];
    bit [31:0] m_hold [4];
    bit        m_pend [4];
    bit        m_run;
    bit [3:0]  m_split;
    bit [7:0]  m_stat, m_mask, m_ovf;
    bit        m_rvalid;
    bit [63:0] m_rdata;
    string     m_tag = "R2";

    function automatic bit [31:0] m_view(int p);
        return m_pend[p] ? m_hold[p] : m_live[p];
    endfunction

    function automatic bit [31:0] m_read(int a);
        bit [31:0] v;
        if (a < 8) begin
            v = m_view(a % 4);
            if (m_split[a % 4]) return (a < 4) ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
            return v;
        end
        if (a == 8) return {27'h0, m_split, m_run};
        if (a == 9) return {24'h0, m_stat};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 4; p++) begin
                m_live[p] = 0; m_hold[p] = 0; m_pend[p] = 0;
            end
            m_run = 0; m_split = 0; m_stat = 0; m_mask = 0; m_rvalid = 0; m_rdata = 0;
        end else begin
            int        a;
            bit        wr, rd, cm;
            bit [31:0] v, w;
            bit [15:0] hi, lo;
            a  = int'(req_addr);
            wr = req_valid && req_write;
            rd = req_valid && !req_write;
            cm = wr && a == 8 && req_wdata[32];
            w  = req_wdata[63:32];
            m_rvalid = rd;
            if (rd) begin
                m_rdata = {m_read(a), 32'h0};
                m_tag   = cur_tag;
            end
            if (wr && a < 8) begin
                int p;
                p = a % 4;
                v = m_view(p);
                if (!m_split[p])  m_hold[p] = w;
                else if (a >= 4)  m_hold[p] = {v[31:16], w[15:0]};
                else              m_hold[p] = {w[15:0], v[15:0]};
                m_pend[p] = 1;
            end
            m_ovf = 0;
            for (int p = 0; p < 4; p++) begin
                if (cm && m_pend[p]) begin
                    m_live[p] = m_hold[p];
                end else if (m_run) begin
                    if (m_split[p]) begin
                        hi = m_live[p][31:16];
                        lo = m_live[p][15:0];
                        if (evt_inc[p])   begin if (hi == 16'hFFFF) m_ovf[p] = 1;   hi = hi + 1; end
                        if (evt_inc[p+4]) begin if (lo == 16'hFFFF) m_ovf[p+4] = 1; lo = lo + 1; end
                        m_live[p] = {hi, lo};
                    end else if (evt_inc[p]) begin
                        if (m_live[p] == 32'hFFFF_FFFF) m_ovf[p] = 1;
                        m_live[p] = m_live[p] + 1;
                    end
                end
            end
            if (wr && a == 8) begin
                m_run   = w[0];
                m_split = w[4:1];
                if (cm) for (int p = 0; p < 4; p++) m_pend[p] = 0;
            end
            if (rd && a == 9) m_stat = 0;
            m_stat = m_stat | m_ovf;
            if (wr && a == 9) m_mask = w[7:0];
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(irq_out === |(m_stat & m_mask), "R10", {63'h0, irq_out}, {63'h0, |(m_stat & m_mask)});
            chk(rsp_valid === m_rvalid, "R2", {63'h0, rsp_valid}, {63'h0, m_rvalid});
            if (m_rvalid) chk(rsp_rdata === m_rdata, m_tag, rsp_rdata, m_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus(input bit we, input int a, input logic [63:0] d, input logic [7:0] inc, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = 1'b1;
        req_write = we;
        req_addr  = 4'(a);
        req_wdata = d;
        evt_inc   = inc;
    endtask

    task automatic idle(input logic [7:0] inc);
        @(negedge clk);
        req_valid = 1'b0;
        evt_inc   = inc;
    endtask

    task automatic wr32(input int a, input logic [31:0] v, input string tag);
        bus(1'b1, a, {v, 32'hDEAD_BEEF}, 8'h0, tag);
    endtask

    task automatic read_chk(input int a, input logic [31:0] exp, input string tag);
        bus(1'b0, a, 64'h0, 8'h0, tag);
        @(negedge clk);
        req_valid = 1'b0;
        evt_inc   = 8'h0;
        chk(rsp_valid === 1'b1 && rsp_rdata === {exp, 32'h0}, tag, rsp_rdata, {exp, 32'h0});
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        idle(8'h0);
        chk(irq_out === exp, tag, {63'h0, irq_out}, {63'h0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_chk(8, 32'h0, "R1");
        read_chk(9, 32'h0, "R1");
        read_chk(0, 32'h0, "R1");
        read_chk(5, 32'h0, "R1");
        irq_chk(1'b0, "R1");

        // R2: low half ignored, holes read zero and ignore writes
        bus(1'b1, 1, {32'h0000_00AA, 32'hFFFF_FFFF}, 8'h0, "R2");
        read_chk(1, 32'h0000_00AA, "R2");
        wr32(13, 32'hFFFF_FFFF, "R2");
        read_chk(12, 32'h0, "R2");
        read_chk(8, 32'h0, "R2");

        // R3: write while stopped stays held
        wr32(0, 32'h1234_5678, "R3");
        repeat (3) idle(8'hFF);
        read_chk(0, 32'h1234_5678, "R3");

        // R4 / R5: start commits, counting
        wr32(8, 32'h1, "R4");
        repeat (5) idle(8'h01);
        idle(8'h0);
        read_chk(0, 32'h1234_567D, "R5");
        wr32(0, 32'h100, "R4");
        repeat (2) idle(8'h01);
        read_chk(0, 32'h100, "R3");
        wr32(8, 32'h1, "R4");
        idle(8'h0);
        read_chk(0, 32'h100, "R4");

        // R6 / R7: split physical counter 1
        wr32(8, 32'h5, "R6");
        read_chk(1, 32'h0, "R7");
        read_chk(5, 32'h00AA, "R7");
        wr32(1, 32'hFFFE, "R7");
        wr32(5, 32'hFFFF, "R7");
        read_chk(1, 32'hFFFE, "R7");
        read_chk(5, 32'hFFFF, "R7");
        wr32(8, 32'h5, "R4");
        repeat (2) idle(8'h22);
        idle(8'h0);
        read_chk(1, 32'h0, "R6");
        read_chk(5, 32'h1, "R6");

        // R8 / R10 / R9
        irq_chk(1'b0, "R10");
        wr32(9, 32'h22, "R10");
        irq_chk(1'b1, "R10");
        read_chk(9, 32'h22, "R8");
        irq_chk(1'b0, "R9");
        read_chk(9, 32'h0, "R9");

        // R9: wrap coinciding with the clearing read
        wr32(5, 32'hFFFF, "R9");
        wr32(8, 32'h5, "R9");
        bus(1'b0, 9, 64'h0, 8'h20, "R9");
        idle(8'h0);
        read_chk(9, 32'h20, "R9");

        // R5: 32-bit counter ignores its second increment input
        wr32(2, 32'h10, "R5");
        wr32(8, 32'h5, "R5");
        repeat (3) idle(8'h40);
        idle(8'h0);
        read_chk(2, 32'h10, "R5");
        repeat (2) idle(8'h04);
        idle(8'h0);
        read_chk(2, 32'h12, "R5");

        // R11: commit beats a same-cycle increment
        wr32(2, 32'h50, "R11");
        bus(1'b1, 8, {32'h5, 32'h0}, 8'h04, "R11");
        idle(8'h0);
        read_chk(2, 32'h50, "R11");
        read_chk(9, 32'h0, "R11");

        // R8: 32-bit wrap
        wr32(3, 32'hFFFF_FFFF, "R8");
        wr32(8, 32'h1, "R8");
        idle(8'h08);
        idle(8'h0);
        read_chk(3, 32'h0, "R8");
        irq_chk(1'b0, "R10");
        wr32(9, 32'h08, "R10");
        irq_chk(1'b1, "R10");
        wr32(9, 32'h0, "R10");
        irq_chk(1'b0, "R10");
        read_chk(9, 32'h08, "R8");

        // R5: stopping freezes counts
        wr32(8, 32'h0, "R5");
        repeat (3) idle(8'hFF);
        read_chk(3, 32'h0, "R5");
        read_chk(2, 32'h50, "R5");

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int          a, k;
            logic [31:0] v;
            a = $urandom_range(0, 11);
            k = $urandom_range(0, 3);
            if (a == 8)      v = {27'h0, 4'($urandom), 1'($urandom_range(0, 4) != 0)};
            else if (a == 9) v = {24'h0, 8'($urandom)};
            else if (k == 0) v = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
            else if (k == 1) v = {12'hFFF, 4'($urandom), 12'hFFF, 4'($urandom)};
            else             v = $urandom;
            case ($urandom_range(0, 3))
                0:       idle(8'($urandom));
                1:       bus(1'b0, a, 64'h0, 8'($urandom), "R7");
                default: bus(1'b1, a, {v, 32'($urandom)}, 8'($urandom), "R4");
            endcase
        end
        idle(8'h0);
        idle(8'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule